// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block takes a DRAM array from reset to a usable state and then keeps its contents alive. After reset it waits out a power-up pause and then drives a fixed number of warm-up refresh cycles on its own, with no bus grant needed. Once warm-up ends it produces a refresh request at a fixed interval. Requests that the access controller cannot serve at once are stored in a small counter and served later, one refresh per grant. All refresh cycles use the CAS-before-RAS form: the row strobe falls only after the column strobe has already been low for a set time, and the write strobe stays high throughout. The DRAM's internal row counter supplies the address, so the block drives no address.

On a host command the block puts the array into self refresh by holding both strobes low. It keeps them low for a minimum time, and longer while the command stays raised. When the command drops, the block precharges the array and then runs a full catch-up burst of refresh cycles. Host access is blocked during initialisation, during self refresh and during the catch-up burst. Access is also blocked whenever the block owns the bus or a refresh grant is present.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, and just after it, all three strobes are high (1), busy is 1, overflow is 0 and access grant is 0.
- R2: The column strobe does not fall until at least PWRUP_CYC cycles after reset is released.
- R3: After the pause the block issues exactly WARM_CNT refresh cycles without needing a grant. Busy is 1 during this time and drops to 0 once the last cycle has finished.
- R4: In every refresh cycle the column strobe is low for at least T_CSR cycles before the row strobe falls. The column strobe stays low for as long as the row strobe is low. The row strobe stays low for T_RAS cycles and is high for at least T_RP cycles before it falls again.
- R5: The write strobe is high (1) in every cycle.
- R6: One refresh becomes due every REF_PERIOD cycles after warm-up. The refresh request is 1 while any refresh is pending, and a refresh cycle starts only while the refresh grant is 1.
- R7: Refreshes that fall due while the grant is 0 are kept. After a grant they are all issued back to back, and the request then drops to 0.
- R8: The overflow flag goes to 1 when more than PEND_LIM refreshes are pending. It stays at 1 until reset.
- R9: A self-refresh request takes priority over pending refreshes when the grant arrives. The row strobe then stays low for at least SR_MIN cycles, and for as long as the request stays at 1. Busy is 1 throughout.
- R10: After self refresh ends, the row strobe stays high for at least SR_PRE cycles. Then exactly BURST_CNT refresh cycles follow with busy at 1, and busy then returns to 0.
- R11: Access grant is 1 only when access is requested, busy is 0, the block is idle and no refresh grant is present. It is 0 whenever the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt_i | input | 1 | Bus grant from the access controller for refresh or self refresh |
| sr_req_i | input | 1 | Host self-refresh command; held at 1 to stay in self refresh |
| acc_req_i | input | 1 | Host access request |
| ref_req_o | output | 1 | Bus request: work is pending or the block owns the bus |
| busy_o | output | 1 | Initialisation, self refresh or catch-up burst in progress |
| acc_gnt_o | output | 1 | Host access allowed this cycle |
| ovf_o | output | 1 | Sticky flag: too many refreshes pending |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low; kept high |

## Verification
Two functions can collide in the same cycle. The first case is a self-refresh command arriving while refreshes are already pending, with both waiting on one grant. The bench builds a backlog by holding the grant low for two intervals, then raises the self-refresh command and only afterwards opens the grant. It then checks that the first row-strobe pulse is a long self-refresh pulse and not a short refresh pulse. The second case is a new refresh falling due in the same cycle that a pending one completes. This happens while a backlog drains and the interval timer keeps running. It is judged by the number of cycles issued before the request drops, and by the requirement that the request then falls to 0 rather than staying stuck.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_CBR_SU,
        ST_CBR_RAS,
        ST_CBR_PRE,
        ST_IDLE,
        ST_SR_SU,
        ST_SR_HOLD,
        ST_SR_PRE
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_WARM,
        MD_SINGLE,
        MD_BURST
    } seq_mode_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic strobe_t strobe_of(seq_state_e s);
        strobe_t o;
        o.ras_n = 1'b1;
        o.cas_n = 1'b1;
        o.we_n  = 1'b1;
        case (s)
            ST_CBR_SU, ST_SR_SU:    o.cas_n = 1'b0;
            ST_CBR_RAS, ST_SR_HOLD: begin
                o.cas_n = 1'b0;
                o.ras_n = 1'b0;
            end
            default: ;
        endcase
        return o;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_tick.sv
module rfs_tick #(
    parameter int PERIOD = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_pending.sv
module rfs_pending #(
    parameter int PEND_LIM = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic pend_nz,
    output logic ovf
);
    localparam int W    = $clog2(2 * PEND_LIM);
    localparam int MAXV = (1 << W) - 1;

    logic [W-1:0] pend, pend_nxt;

    always_comb begin
        if (clr) begin
            pend_nxt = W'(inc);
        end else if (inc && !dec) begin
            pend_nxt = (pend == W'(MAXV)) ? pend : pend + 1'b1;
        end else if (dec && !inc) begin
            pend_nxt = pend - 1'b1;
        end else begin
            pend_nxt = pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ovf  <= 1'b0;
        end else begin
            pend <= pend_nxt;
            if (pend_nxt > W'(PEND_LIM)) ovf <= 1'b1;
        end
    end

    assign pend_nz = (pend != '0);

    // R7: a completion is reported only when something is pending
    assert_dec_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        dec |-> pend_nz);
    // R8: overflow is sticky
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

// File: rtl/rfs_fsm.sv
module rfs_fsm
    import dram_ref_pkg::*;
#(
    parameter int PWRUP_CYC = 50000,
    parameter int WARM_CNT  = 8,
    parameter int BURST_CNT = 8192,
    parameter int T_CSR     = 3,
    parameter int T_RAS     = 13,
    parameter int T_RP      = 10,
    parameter int SR_MIN    = 25000,
    parameter int SR_PRE    = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pend_nz,
    input  logic       ref_gnt_i,
    input  logic       sr_req_i,
    output seq_state_e st,
    output logic       init_done,
    output logic       dec,
    output logic       clr,
    output logic       ref_req,
    output logic       busy
);
    localparam int TMAX = max2(max2(PWRUP_CYC, SR_MIN),
                               max2(max2(T_CSR, T_RAS), max2(T_RP, SR_PRE)));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int SW   = $clog2(max2(WARM_CNT, BURST_CNT) + 1);

    seq_state_e      st_nxt;
    seq_mode_e       mode;
    logic [TW-1:0]   tmr;
    logic [SW-1:0]   left;
    int              lim;
    logic            tdone, sr_ok, owns;

    always_comb begin
        case (st)
            ST_PWRUP:             lim = PWRUP_CYC;
            ST_CBR_SU, ST_SR_SU:  lim = T_CSR;
            ST_CBR_RAS:           lim = T_RAS;
            ST_CBR_PRE:           lim = T_RP;
            ST_SR_PRE:            lim = SR_PRE;
            default:              lim = 1;
        endcase
    end

    assign tdone = (int'(tmr) == lim - 1);
    assign sr_ok = (int'(tmr) >= SR_MIN - 1) && !sr_req_i;

    always_comb begin
        st_nxt = st;
        case (st)
            ST_PWRUP:   if (tdone) st_nxt = ST_CBR_SU;
            ST_CBR_SU:  if (tdone) st_nxt = ST_CBR_RAS;
            ST_CBR_RAS: if (tdone) st_nxt = ST_CBR_PRE;
            ST_CBR_PRE: if (tdone) st_nxt = (mode == MD_SINGLE || left == SW'(1))
                                            ? ST_IDLE : ST_CBR_SU;
            ST_IDLE: begin
                if (ref_gnt_i && sr_req_i)     st_nxt = ST_SR_SU;
                else if (ref_gnt_i && pend_nz) st_nxt = ST_CBR_SU;
            end
            ST_SR_SU:   if (tdone) st_nxt = ST_SR_HOLD;
            ST_SR_HOLD: if (sr_ok) st_nxt = ST_SR_PRE;
            ST_SR_PRE:  if (tdone) st_nxt = ST_CBR_SU;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PWRUP;
            mode      <= MD_WARM;
            tmr       <= '0;
            left      <= '0;
            init_done <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st_nxt != st)    tmr <= '0;
            else if (tmr != '1)  tmr <= tmr + 1'b1;
            case (st)
                ST_PWRUP: if (tdone) begin
                    mode <= MD_WARM;
                    left <= SW'(WARM_CNT);
                end
                ST_IDLE: if (ref_gnt_i && !sr_req_i && pend_nz) mode <= MD_SINGLE;
                ST_CBR_PRE: if (tdone && mode != MD_SINGLE) begin
                    left <= left - 1'b1;
                    if (left == SW'(1) && mode == MD_WARM) init_done <= 1'b1;
                end
                ST_SR_PRE: if (tdone) begin
                    mode <= MD_BURST;
                    left <= SW'(BURST_CNT);
                end
                default: ;
            endcase
        end
    end

    assign dec  = (st == ST_CBR_PRE) && tdone && (mode == MD_SINGLE);
    assign clr  = (st == ST_SR_HOLD) && sr_ok;
    assign owns = (st != ST_IDLE) && (st != ST_PWRUP);
    assign ref_req = owns || ((st == ST_IDLE) && (pend_nz || sr_req_i));
    assign busy = (st == ST_PWRUP) || (st == ST_SR_SU) || (st == ST_SR_HOLD) ||
                  (st == ST_SR_PRE) || (owns && mode != MD_SINGLE);

    // R9: self refresh is not left while the host still asks for it
    assert_sr_held_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SR_HOLD && sr_req_i) |=> (st == ST_SR_HOLD));
    // R6: a single refresh starts from idle only under a grant
    assert_start_on_grant_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !ref_gnt_i) |=> (st == ST_IDLE));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int PWRUP_CYC  = 50000,
    parameter int WARM_CNT   = 8,
    parameter int BURST_CNT  = 8192,
    parameter int REF_PERIOD = 3900,
    parameter int PEND_LIM   = 8,
    parameter int T_CSR      = 3,
    parameter int T_RAS      = 13,
    parameter int T_RP       = 10,
    parameter int SR_MIN     = 25000,
    parameter int SR_PRE     = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt_i,
    input  logic sr_req_i,
    input  logic acc_req_i,
    output logic ref_req_o,
    output logic busy_o,
    output logic acc_gnt_o,
    output logic ovf_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o
);
    seq_state_e st;
    strobe_t    stb;
    logic       init_done, tick, dec, clr, pend_nz;

    rfs_tick #(.PERIOD(REF_PERIOD)) u_tick (
        .clk (clk), .rst (rst), .en (init_done), .tick (tick)
    );

    rfs_pending #(.PEND_LIM(PEND_LIM)) u_pend (
        .clk (clk), .rst (rst), .inc (tick), .dec (dec), .clr (clr),
        .pend_nz (pend_nz), .ovf (ovf_o)
    );

    rfs_fsm #(
        .PWRUP_CYC (PWRUP_CYC), .WARM_CNT (WARM_CNT), .BURST_CNT (BURST_CNT),
        .T_CSR (T_CSR), .T_RAS (T_RAS), .T_RP (T_RP),
        .SR_MIN (SR_MIN), .SR_PRE (SR_PRE)
    ) u_fsm (
        .clk (clk), .rst (rst), .pend_nz (pend_nz), .ref_gnt_i (ref_gnt_i),
        .sr_req_i (sr_req_i), .st (st), .init_done (init_done), .dec (dec),
        .clr (clr), .ref_req (ref_req_o), .busy (busy_o)
    );

    assign stb       = strobe_of(st);
    assign ras_n_o   = stb.ras_n;
    assign cas_n_o   = stb.cas_n;
    assign we_n_o    = stb.we_n;
    assign acc_gnt_o = acc_req_i && !busy_o && (st == ST_IDLE) && !ref_gnt_i;

    // R4: row strobe falls only after the column strobe is already low
    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> $past(!cas_n_o));
    // R4: column strobe held low while the row strobe is low
    assert_cas_held_R4: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> !cas_n_o);
    // R11: no host access while busy
    assert_no_acc_busy_R11: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !acc_gnt_o);
    // R11: no host access while the row strobe is low
    assert_no_acc_ras_R11: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> !acc_gnt_o);
endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
    localparam int PWRUP = 20, WARM = 8, BURST = 16, PER = 60, LIM = 8;
    localparam int TCSR = 3, TRAS = 4, TRP = 3, SRMIN = 30, SRPRE = 5;

    logic clk = 0, rst = 1, auto_gnt = 0, sr_req = 0, acc_req = 0;
    logic ref_gnt, ref_req, busy, acc_gnt, ovf, ras_n, cas_n, we_n;
    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;
    assign ref_gnt = auto_gnt ? ref_req : 1'b0;

    dram_refresh_seq #(
        .PWRUP_CYC(PWRUP), .WARM_CNT(WARM), .BURST_CNT(BURST), .REF_PERIOD(PER),
        .PEND_LIM(LIM), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP),
        .SR_MIN(SRMIN), .SR_PRE(SRPRE)
    ) u_dut (
        .clk(clk), .rst(rst), .ref_gnt_i(ref_gnt), .sr_req_i(sr_req),
        .acc_req_i(acc_req), .ref_req_o(ref_req), .busy_o(busy),
        .acc_gnt_o(acc_gnt), .ovf_o(ovf), .ras_n_o(ras_n), .cas_n_o(cas_n),
        .we_n_o(we_n)
    );

    // strobe monitor
    int cbr_cnt, busy_cbr, sr_cnt, last_sr_len, sr_pre_len, first_kind;
    int viol, we_low, accbad, cas_run, lo_run, hi_run;
    logic prev_ras, after_sr;
    always @(negedge clk) begin
        if (rst) begin
            cbr_cnt = 0; busy_cbr = 0; sr_cnt = 0; last_sr_len = 0; sr_pre_len = 0;
            first_kind = 0; viol = 0; we_low = 0; accbad = 0; cas_run = 0;
            lo_run = 0; hi_run = 0; prev_ras = 1; after_sr = 0;
        end else begin
            if (!ras_n && prev_ras) begin
                if (cas_run < TCSR) viol++;
                if (hi_run < TRP) viol++;
                if (after_sr) begin sr_pre_len = hi_run; after_sr = 0; end
            end
            if (ras_n && !prev_ras) begin
                if (lo_run >= SRMIN) begin
                    sr_cnt++; last_sr_len = lo_run; after_sr = 1;
                    if (first_kind == 0) first_kind = 2;
                end else begin
                    cbr_cnt++;
                    if (lo_run != TRAS) viol++;
                    if (busy) busy_cbr++;
                    if (first_kind == 0) first_kind = 1;
                end
            end
            if (!ras_n && cas_n) viol++;
            if (!we_n) we_low++;
            if (!ras_n && acc_gnt) accbad++;
            cas_run  = cas_n ? 0 : cas_run + 1;
            lo_run   = ras_n ? 0 : lo_run + 1;
            hi_run   = ras_n ? hi_run + 1 : 0;
            prev_ras = ras_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        acc_req = 1;
        repeat (3) @(negedge clk);
        check(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
        check(busy == 1, "R1 busy", busy, 1);
        check(ovf == 0, "R1 ovf", ovf, 0);
        check(acc_gnt == 0, "R1 acc_gnt", acc_gnt, 0);
        rst = 0;
        @(negedge clk);
        check(ras_n && cas_n && busy && !acc_gnt, "R1 after release",
              {ras_n, cas_n, busy, acc_gnt}, 14);
    endtask

    task automatic t_powerup_warm();
        int hi = 1;
        while (cas_n && hi < 1000) begin @(negedge clk); if (cas_n) hi++; end
        check(hi >= PWRUP - 1 && hi <= PWRUP + 1, "R2 pause", hi, PWRUP - 1);
        check(busy && !acc_gnt, "R3 access blocked in warm-up", acc_gnt, 0);
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
        check(cbr_cnt == WARM, "R3 warm-up count", cbr_cnt, WARM);
        check(busy == 0, "R3 busy drops", busy, 0);
        check(ref_req == 0 && acc_gnt == 1, "R11 idle access granted",
              {ref_req, acc_gnt}, 1);
    endtask

    task automatic t_periodic();
        int c0 = cbr_cnt;
        auto_gnt = 1;
        repeat (600) @(negedge clk);
        check(cbr_cnt - c0 >= 9 && cbr_cnt - c0 <= 11, "R6 periodic rate",
              cbr_cnt - c0, 10);
        check(accbad == 0, "R11 no access during refresh", accbad, 0);
    endtask

    task automatic t_deferred();
        int c0;
        while (ref_req) @(negedge clk);
        auto_gnt = 0;
        c0 = cbr_cnt;
        repeat (5 * PER) @(negedge clk);
        check(cbr_cnt == c0, "R6 no refresh without grant", cbr_cnt - c0, 0);
        check(ref_req == 1, "R6 request while pending", ref_req, 1);
        auto_gnt = 1;
        @(negedge clk);
        for (int i = 0; i < 400 && ref_req; i++) @(negedge clk);
        check(cbr_cnt - c0 >= 4 && cbr_cnt - c0 <= 7, "R7 backlog issued",
              cbr_cnt - c0, 5);
        check(ref_req == 0, "R7 request drops after backlog", ref_req, 0);
    endtask

    task automatic t_selfref();
        int s0 = sr_cnt;
        bit busy_ok = 1;
        auto_gnt = 0;
        repeat (2 * PER + 5) @(negedge clk);
        sr_req = 1;
        @(negedge clk);
        first_kind = 0;
        auto_gnt = 1;
        for (int i = 0; i < 100 && ras_n; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        sr_req = 0;
        busy_cbr = 0;
        for (int i = 0; i < 1000 && (busy || !ras_n); i++) begin
            if (!ras_n && !busy) busy_ok = 0;
            @(negedge clk);
        end
        check(first_kind == 2, "R9 self refresh has priority", first_kind, 2);
        check(sr_cnt == s0 + 1, "R9 one self-refresh pulse", sr_cnt - s0, 1);
        check(last_sr_len >= SRMIN, "R9 minimum hold", last_sr_len, SRMIN);
        check(busy_ok, "R9 busy during self refresh", busy_ok, 1);
        check(sr_pre_len >= SRPRE, "R10 precharge after exit", sr_pre_len, SRPRE);
        check(busy_cbr == BURST, "R10 catch-up burst", busy_cbr, BURST);
        check(busy == 0, "R10 busy released", busy, 0);
    endtask

    task automatic t_overflow();
        auto_gnt = 1;
        for (int i = 0; i < 400 && ref_req; i++) @(negedge clk);
        auto_gnt = 0;
        repeat (7 * PER) @(negedge clk);
        check(ovf == 0, "R8 no overflow at limit", ovf, 0);
        repeat (3 * PER) @(negedge clk);
        check(ovf == 1, "R8 overflow set", ovf, 1);
        auto_gnt = 1;
        repeat (20) @(negedge clk);
        check(ovf == 1, "R8 overflow sticky", ovf, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_powerup_warm();
        t_periodic();
        t_deferred();
        t_selfref();
        t_overflow();
        check(viol == 0, "R4 strobe ordering and widths", viol, 0);
        check(we_low == 0, "R5 write strobe high", we_low, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule